// File: doc/BRIEF.md
# Linear-Scan Oblivious Lookup Table

This block is a small key-value store whose physical access pattern reveals nothing about the requests it serves. Each stored slot carries a valid bit, an 8-bit logical tag and a 16-bit value. When a request arrives, the block touches every occupied slot in turn, from slot 0 upward, and writes each one back. During this sweep it compares each tag with the requested key. A write changes the first valid slot that matches. A read copies that slot's value.

After the sweep the block always fills one more slot at the end of the table. A write whose key was not found puts the new pair there. Every other request (any read, or a write that hit) puts an invalid placeholder there. The table therefore grows by exactly one slot per request. The physical index sequence depends only on how many requests came before. The cost of a request grows linearly with the history, so the cost of a run grows quadratically. Once every slot is used, the block reports full and takes no more requests.

A surrounding wrapper that encrypts values would sit between this block and any external store. The physical index output exists so that the access order can be observed.

Top module: `oblv_scan_table`

## Requirements
- R1: For an accepted request, with L the table length at acceptance, `phys_en` is high for exactly L+1 consecutive cycles. During them, `phys_idx` takes the values 0, 1, …, L in order, one per cycle; the last cycle is the append.
- R2: The sequence of `phys_idx` values for a request is the same whatever the operation, key or data.
- R3: The table length is 0 after reset. Every completed request raises it by exactly one: reads and writes, hits and misses alike.
- R4: A write to a key that is not present stores the pair in the appended slot. A later read of that key returns `rsp_hit`=1 and the written value.
- R5: A write to a key that is present updates that slot in place. Later reads of the key return the new value.
- R6: A read of a key that is not present returns `rsp_hit`=0 and `rsp_rdata`=0.
- R7: `rsp_valid` is a single-cycle pulse. It is raised at the (L+2)th rising edge counting the acceptance edge as the first; in other words, L+1 edges after the accepting edge.
- R8: When the length equals the depth (64), `full`=1 and `req_ready`=0. Requests presented then start no sweep and produce no response.
- R9: After reset, `req_ready`=1 and `full`=0, `rsp_valid`=0 and `phys_en`=0.
- R10: A write response reports in `rsp_hit` whether the key was found, and always returns `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle and not full; a request is taken when both are high at an edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Logical key |
| req_wdata | input | 16 | Value to write |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Key was found during the sweep |
| rsp_rdata | output | 16 | Read value (0 on a miss or a write) |
| full | output | 1 | Every slot has been used |
| phys_en | output | 1 | A slot is being touched this cycle |
| phys_idx | output | 6 | Index of the slot being touched |

## Verification
The hardest state to reach is the full table. Only 64 complete requests get there, and each one costs a sweep longer than the one before. The stimulus reaches it with a loop that mixes writes to new keys, rewrites and reads until the model's length is 64. It then holds a request at the input for several cycles and checks that no sweep and no response follow. Key 0 is exercised on purpose, because the placeholder slots also carry tag 0; only their valid bit keeps them from matching.

// File: rtl/oblv_pkg.sv
package oblv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_APPEND = 2'd2,
        ST_RESP   = 2'd3
    } phase_e;
endpackage

// File: rtl/oblv_cmp.sv
module oblv_cmp #(
    parameter int AW = 8
) (
    input  logic          ent_valid,
    input  logic [AW-1:0] ent_addr,
    input  logic [AW-1:0] key,
    output logic          match
);
    always_comb begin
        match = ent_valid && (ent_addr == key);
    end
endmodule

// File: rtl/oblv_store.sv
module oblv_store #(
    parameter int DEPTH = 64,
    parameter int ENT_W = 25,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [ENT_W-1:0] wr_ent,
    output logic [ENT_W-1:0] rd_ent
);
    typedef struct packed {
        logic [DEPTH-1:0][ENT_W-1:0] ent;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.ent[idx] = wr_ent;
        end
        rd_ent = s_q.ent[idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/oblv_seq.sv
module oblv_seq
    import oblv_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    parameter int IDX_W = 6,
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_ready,
    input  logic             rd_valid,
    input  logic [AW-1:0]    rd_addr,
    input  logic [DW-1:0]    rd_data,
    input  logic             cmp_hit,
    output logic [AW-1:0]    key,
    output logic             wr_en,
    output logic             wr_valid,
    output logic [AW-1:0]    wr_addr,
    output logic [DW-1:0]    wr_data,
    output logic [IDX_W-1:0] idx,
    output logic             phys_en,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [DW-1:0]    rsp_rdata,
    output logic             full
);
    typedef struct packed {
        phase_e           ph;
        logic [IDX_W-1:0] idx;
        logic [LEN_W-1:0] len;
        logic             wr;
        logic [AW-1:0]    key;
        logic [DW-1:0]    wdata;
        logic             hit;
        logic [DW-1:0]    rdata;
    } seq_t;

    seq_t n_d, q_q;

    always_comb begin
        n_d       = q_q;
        wr_en     = 1'b0;
        wr_valid  = 1'b0;
        wr_addr   = '0;
        wr_data   = '0;
        full      = (q_q.len == LEN_W'(DEPTH));
        req_ready = (q_q.ph == ST_IDLE) && !full;
        case (q_q.ph)
            ST_IDLE: begin
                if (req_valid && req_ready) begin
                    n_d.wr    = req_write;
                    n_d.key   = req_addr;
                    n_d.wdata = req_wdata;
                    n_d.hit   = 1'b0;
                    n_d.rdata = '0;
                    n_d.idx   = '0;
                    n_d.ph    = (q_q.len == '0) ? ST_APPEND : ST_SCAN;
                end
            end
            ST_SCAN: begin
                wr_en    = 1'b1;
                wr_valid = rd_valid;
                wr_addr  = rd_addr;
                wr_data  = rd_data;
                if (cmp_hit && !q_q.hit) begin
                    n_d.hit = 1'b1;
                    if (q_q.wr) begin
                        wr_data = q_q.wdata;
                    end else begin
                        n_d.rdata = rd_data;
                    end
                end
                n_d.idx = q_q.idx + 1'b1;
                if (LEN_W'(q_q.idx) + 1'b1 == q_q.len) begin
                    n_d.ph = ST_APPEND;
                end
            end
            ST_APPEND: begin
                wr_en = 1'b1;
                if (q_q.wr && !q_q.hit) begin
                    wr_valid = 1'b1;
                    wr_addr  = q_q.key;
                    wr_data  = q_q.wdata;
                end
                n_d.len = q_q.len + 1'b1;
                n_d.ph  = ST_RESP;
            end
            default: begin
                n_d.ph = ST_IDLE;
            end
        endcase
        key       = q_q.key;
        idx       = q_q.idx;
        phys_en   = (q_q.ph == ST_SCAN) || (q_q.ph == ST_APPEND);
        rsp_valid = (q_q.ph == ST_RESP);
        rsp_hit   = q_q.hit;
        rsp_rdata = q_q.rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q    <= '0;
            q_q.ph <= ST_IDLE;
        end else begin
            q_q <= n_d;
        end
    end

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.ph == ST_SCAN) |=> (idx == $past(idx) + 1'b1)); // R1
    AST_SWEEP_START: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (phys_en && idx == '0)); // R1
    AST_LEN_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (q_q.len == $past(q_q.len) + 1'b1)); // R3
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (full && q_q.ph == ST_IDLE) |=> !phys_en); // R8
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R7
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.len <= LEN_W'(DEPTH)); // R8
endmodule

// File: rtl/oblv_scan_table.sv
module oblv_scan_table #(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1),
    localparam int ENT_W = 1 + AW + DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [DW-1:0]    rsp_rdata,
    output logic             full,
    output logic             phys_en,
    output logic [IDX_W-1:0] phys_idx
);
    logic [ENT_W-1:0] rd_ent;
    logic [ENT_W-1:0] wr_ent;
    logic             wr_en;
    logic             wr_valid;
    logic [AW-1:0]    wr_addr;
    logic [DW-1:0]    wr_data;
    logic [AW-1:0]    key;
    logic             cmp_hit;

    assign wr_ent = {wr_valid, wr_addr, wr_data};

    oblv_store #(.DEPTH(DEPTH), .ENT_W(ENT_W), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .idx    (phys_idx),
        .wr_ent (wr_ent),
        .rd_ent (rd_ent)
    );

    oblv_cmp #(.AW(AW)) u_cmp (
        .ent_valid (rd_ent[ENT_W-1]),
        .ent_addr  (rd_ent[DW +: AW]),
        .key       (key),
        .match     (cmp_hit)
    );

    oblv_seq #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rd_valid  (rd_ent[ENT_W-1]),
        .rd_addr   (rd_ent[DW +: AW]),
        .rd_data   (rd_ent[DW-1:0]),
        .cmp_hit   (cmp_hit),
        .key       (key),
        .wr_en     (wr_en),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .idx       (phys_idx),
        .phys_en   (phys_en),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_rdata (rsp_rdata),
        .full      (full)
    );
endmodule

// File: tb/oblv_scan_table_tb.sv
`timescale 1ns/1ps
module oblv_scan_table_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [15:0] rsp_rdata;
    logic        full;
    logic        phys_en;
    logic [5:0]  phys_idx;

    always #2 clk = ~clk;

    oblv_scan_table u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_rdata (rsp_rdata),
        .full (full), .phys_en (phys_en), .phys_idx (phys_idx)
    );

    typedef struct {
        bit          hit;
        bit [15:0]   data;
        int          due;
        int          len;
        string       tag;
    } exp_t;

    exp_t      sb[$];
    bit [15:0] model [bit [7:0]];
    int        mlen   = 0;
    int        errs   = 0;
    int        checks = 0;
    int        cyc    = 0;
    int        tr     = 0;
    bit        tr_bad = 1'b0;
    bit        done   = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    task automatic do_req(input bit w, input bit [7:0] a, input bit [15:0] d,
                          input string tag);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e.hit = model.exists(a);
        if (w) begin
            e.data   = 16'h0;  // R10: write answers with zero data
            model[a] = d;
        end else begin
            e.data = e.hit ? model[a] : 16'h0;
        end
        e.len = mlen;
        e.due = cyc + 1 + mlen + 1;  // R7
        e.tag = tag;
        mlen++;
        sb.push_back(e);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (phys_en) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R8", "sweep without accepted request", 1, 0);
                end else begin
                    if (int'(phys_idx) != tr) tr_bad = 1'b1;
                    tr++;
                end
            end
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R7", "response without request", 1, 0);
                end else begin
                    e = sb.pop_front();
                    chk(rsp_hit == e.hit, e.tag, "rsp_hit", rsp_hit, e.hit);
                    chk(rsp_rdata == e.data, e.tag, "rsp_rdata", rsp_rdata, e.data);
                    chk(cyc == e.due, "R7", "response cycle", cyc, e.due);
                    chk(!tr_bad && tr == e.len + 1, "R1 R2 R3", "sweep length", tr, e.len + 1);
                    tr     = 0;
                    tr_bad = 1'b0;
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(req_ready == 1'b1, "R9", "req_ready after reset", req_ready, 1);
        chk(full == 1'b0, "R9", "full after reset", full, 0);
        chk(rsp_valid == 1'b0, "R9", "rsp_valid after reset", rsp_valid, 0);
        chk(phys_en == 1'b0, "R9", "phys_en after reset", phys_en, 0);
        rst_n = 1'b1;

        do_req(1'b1, 8'h10, 16'h1234, "R4");
        do_req(1'b0, 8'h10, 16'h0,    "R4");
        do_req(1'b0, 8'h55, 16'h0,    "R6");
        do_req(1'b1, 8'h10, 16'hBEEF, "R5 R10");
        do_req(1'b0, 8'h10, 16'h0,    "R5");
        do_req(1'b0, 8'h00, 16'h0,    "R6");
        do_req(1'b1, 8'h00, 16'h0002, "R4");
        do_req(1'b0, 8'h00, 16'h0,    "R4");
        do_req(1'b0, 8'hFF, 16'h0,    "R6");

        for (int i = 0; mlen < 64; i++) begin
            if (i % 3 == 2) begin
                do_req(1'b0, 8'(i * 5), 16'h0, "R4 R6");
            end else begin
                do_req(1'b1, 8'(i * 37 + 3), 16'(i * 911 + 7), "R4 R5 R10");
            end
        end

        chk(full == 1'b1, "R3 R8", "full after 64 requests", full, 1);
        chk(req_ready == 1'b0, "R8", "req_ready when full", req_ready, 0);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = 8'h77;
        req_wdata = 16'h5A5A;
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R8", "no response when full", sb.size(), 0);
        chk(phys_en == 1'b0, "R8", "no sweep when full", phys_en, 0);
        chk(full == 1'b1, "R8", "still full", full, 1);
        finish_run();
    end
endmodule